// File: doc/BRIEF.md
# Radio Packet Framer and Address Filter

This block sits between a node's packet logic and the byte FIFOs of a short-range radio. On the transmit side it takes a destination address and a 32-bit payload, adds the node's own address as source, and streams out a frame one byte at a time. The frame opens with a length byte, and two CRC placeholder bytes filled with zeros close it. The radio adds its own preamble and start delimiter and overwrites the CRC bytes, so the block produces neither.

On the receive side the block takes the byte stream drained from the radio's receive FIFO and reads each frame from its length byte. A frame is accepted only if three things hold: its length equals the fixed frame size, its destination is this node or the broadcast address, and it does not come from this node. An accepted frame produces a one-cycle push of source and payload into a downstream FIFO. Every other frame is consumed to its declared end and dropped, so foreign or malformed traffic never breaks byte alignment. The node address is an input and may change between frames without a reset.

Top module: `radio_frame_codec`

## Requirements
- R1: After reset `txReady` is 1 and `txValid` is 0. A `txStart` seen while `txReady` is 1 latches the request and drops `txReady` on the next cycle. `txReady` returns to 1 only after the last frame byte has been accepted. A `txStart` while busy is ignored.
- R2: A transmitted frame is 9 bytes, in this order: length 0x08, destination, local address, payload bits 31:24, 23:16, 15:8, 7:0, then 0x00 and 0x00.
- R3: While `txValid` is 1 and `txAccept` is 0, `txValid` stays 1 and `txByte` holds its value on the next cycle.
- R4: A received frame with length byte 0x08 and destination equal to `localAddr` raises `outPush` for exactly one cycle. This happens in the cycle after the clock edge that takes its last byte, with `outSrc` set to body byte 1 and `outPayload` set to body bytes 2..5 (most significant byte first).
- R5: A frame addressed to 0xFF is accepted like a frame addressed to `localAddr`.
- R6: A frame whose destination is neither `localAddr` nor 0xFF produces no push.
- R7: A frame whose destination is 0x00 produces no push.
- R8: A frame whose source equals `localAddr` produces no push, even when it is broadcast.
- R9: A length byte other than 0x08 causes exactly that many following bytes to be consumed without a push. A length of 0 consumes no body bytes. The byte after a dropped frame is read as the next length byte.
- R10: `outPush` stays 0 while a frame is in progress. `outPayload` and `outSrc` change only on a push. Cycles with `rxValid` low have no effect.
- R11: After reset `outPush` is 0 and `outPayload` and `outSrc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localAddr | input | 8 | This node's address, used as TX source and for RX matching |
| txStart | input | 1 | Request to send a frame |
| txDest | input | 8 | Destination address of the frame to send |
| txPayload | input | 32 | Payload of the frame to send |
| txReady | output | 1 | Framer idle and able to take a request |
| txByte | output | 8 | Current outgoing frame byte |
| txValid | output | 1 | `txByte` is valid |
| txAccept | input | 1 | Downstream takes `txByte` at this edge |
| rxByte | input | 8 | Byte read from the radio receive FIFO |
| rxValid | input | 1 | `rxByte` is valid this cycle |
| outPush | output | 1 | One-cycle push of an accepted frame |
| outSrc | output | 8 | Source address of the last accepted frame |
| outPayload | output | 32 | Payload of the last accepted frame |

## Verification
The bench drives receive frames that differ in one field at a time: destination (own, broadcast, foreign, zero), source (own), and length (zero, short, long). A filter that compared the wrong field would push foreign or looped-back frames. A filter that ignored broadcast would drop valid traffic. A parser that stopped at the nominal size instead of the declared length would read the tail of a long frame as a new length and lose alignment, which the bench catches with a good frame sent right after each bad one. On transmit the bench stalls the consumer and sends a second start while busy. A framer that advanced on a stall, reordered the payload, or relatched its inputs would emit a wrong byte in a known position.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam logic [7:0] BCAST_ADDR = 8'hFF;

  typedef struct packed {
    logic capDest;
    logic capSrc;
    logic capPay;
    logic commit;
  } rxStrobe_t;
endpackage

// File: rtl/rfc_tx_framer.sv
module rfc_tx_framer #(
  parameter int PAY_BYTES = 4,
  parameter int CRC_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             localAddr,
  input  logic                   txStart,
  input  logic [7:0]             txDest,
  input  logic [PAY_BYTES*8-1:0] txPayload,
  output logic                   txReady,
  output logic [7:0]             txByte,
  output logic                   txValid,
  input  logic                   txAccept
);
  localparam int PAY_W = PAY_BYTES * 8;
  localparam int FRAME_LEN = 2 + PAY_BYTES + CRC_BYTES;
  localparam logic [7:0] LEN_BYTE = 8'(FRAME_LEN);
  localparam logic [7:0] PAY_FIRST = 8'd3;
  localparam logic [7:0] PAY_END = 8'(3 + PAY_BYTES);

  logic             busy;
  logic [7:0]       idx;
  logic [7:0]       destQ, srcQ;
  logic [PAY_W-1:0] payQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      idx   <= '0;
      destQ <= '0;
      srcQ  <= '0;
      payQ  <= '0;
    end else if (!busy) begin
      if (txStart) begin
        busy  <= 1'b1;
        idx   <= '0;
        destQ <= txDest;
        srcQ  <= localAddr;
        payQ  <= txPayload;
      end
    end else if (txAccept) begin
      if (idx == LEN_BYTE) busy <= 1'b0;
      else idx <= idx + 8'd1;
      if (idx >= PAY_FIRST && idx < PAY_END) payQ <= payQ << 8;
    end
  end

  always_comb begin
    if (idx == 8'd0)         txByte = LEN_BYTE;
    else if (idx == 8'd1)    txByte = destQ;
    else if (idx == 8'd2)    txByte = srcQ;
    else if (idx < PAY_END)  txByte = payQ[PAY_W-1 -: 8];
    else                     txByte = 8'h00;
  end

  assign txValid = busy;
  assign txReady = !busy;

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txAccept) |=> (txValid && $stable(txByte)));

  assert_len_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> (txByte == LEN_BYTE));
endmodule

// File: rtl/rfc_rx_ctrl.sv
module rfc_rx_ctrl #(
  parameter int PAY_BYTES = 4,
  parameter int CRC_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           rxByte,
  input  logic                 rxValid,
  output rfc_pkg::rxStrobe_t   strobe
);
  localparam int FRAME_LEN = 2 + PAY_BYTES + CRC_BYTES;
  localparam logic [7:0] LEN_BYTE = 8'(FRAME_LEN);
  localparam logic [7:0] PAY_END = 8'(2 + PAY_BYTES);

  logic       inBody;
  logic       lenOk;
  logic [7:0] remaining;
  logic [7:0] bodyIdx;
  logic       take;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBody    <= 1'b0;
      lenOk     <= 1'b0;
      remaining <= '0;
      bodyIdx   <= '0;
    end else if (rxValid) begin
      if (!inBody) begin
        if (rxByte != 8'd0) begin
          inBody    <= 1'b1;
          remaining <= rxByte;
          lenOk     <= (rxByte == LEN_BYTE);
          bodyIdx   <= '0;
        end
      end else begin
        remaining <= remaining - 8'd1;
        bodyIdx   <= bodyIdx + 8'd1;
        if (remaining == 8'd1) inBody <= 1'b0;
      end
    end
  end

  assign take = rxValid && inBody && lenOk;

  always_comb begin
    strobe.capDest = take && (bodyIdx == 8'd0);
    strobe.capSrc  = take && (bodyIdx == 8'd1);
    strobe.capPay  = take && (bodyIdx >= 8'd2) && (bodyIdx < PAY_END);
    strobe.commit  = take && (remaining == 8'd1);
  end

  assert_body_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    inBody |-> (remaining != 8'd0));
endmodule

// File: rtl/rfc_rx_data.sv
module rfc_rx_data #(
  parameter int PAY_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             rxByte,
  input  logic [7:0]             localAddr,
  input  rfc_pkg::rxStrobe_t     strobe,
  output logic                   outPush,
  output logic [7:0]             outSrc,
  output logic [PAY_BYTES*8-1:0] outPayload
);
  localparam int PAY_W = PAY_BYTES * 8;

  logic [7:0]       destReg, srcReg;
  logic [PAY_W-1:0] payReg;
  logic             addrOk;

  assign addrOk = (destReg != 8'h00) && (srcReg != localAddr) &&
                  ((destReg == localAddr) || (destReg == rfc_pkg::BCAST_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destReg    <= '0;
      srcReg     <= '0;
      payReg     <= '0;
      outPush    <= 1'b0;
      outSrc     <= '0;
      outPayload <= '0;
    end else begin
      if (strobe.capDest) destReg <= rxByte;
      if (strobe.capSrc)  srcReg  <= rxByte;
      if (strobe.capPay)  payReg  <= {payReg[PAY_W-9:0], rxByte};
      outPush <= strobe.commit && addrOk;
      if (strobe.commit && addrOk) begin
        outSrc     <= srcReg;
        outPayload <= payReg;
      end
    end
  end

  assert_single_push_R4: assert property (@(posedge clk) disable iff (!rstN)
    outPush |=> !outPush);

  assert_no_self_R8: assert property (@(posedge clk) disable iff (!rstN)
    outPush |-> (outSrc != $past(localAddr)));

  assert_no_zero_dest_R7: assert property (@(posedge clk) disable iff (!rstN)
    outPush |-> (destReg != 8'h00));

  assert_stable_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outPush |-> ($stable(outPayload) && $stable(outSrc)));
endmodule

// File: rtl/radio_frame_codec.sv
module radio_frame_codec #(
  parameter int PAY_BYTES = 4,
  parameter int CRC_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             localAddr,
  input  logic                   txStart,
  input  logic [7:0]             txDest,
  input  logic [PAY_BYTES*8-1:0] txPayload,
  output logic                   txReady,
  output logic [7:0]             txByte,
  output logic                   txValid,
  input  logic                   txAccept,
  input  logic [7:0]             rxByte,
  input  logic                   rxValid,
  output logic                   outPush,
  output logic [7:0]             outSrc,
  output logic [PAY_BYTES*8-1:0] outPayload
);
  rfc_pkg::rxStrobe_t rxStrobe;

  rfc_tx_framer #(.PAY_BYTES(PAY_BYTES), .CRC_BYTES(CRC_BYTES)) uTx (
    .clk(clk), .rstN(rstN), .localAddr(localAddr), .txStart(txStart),
    .txDest(txDest), .txPayload(txPayload), .txReady(txReady),
    .txByte(txByte), .txValid(txValid), .txAccept(txAccept)
  );

  rfc_rx_ctrl #(.PAY_BYTES(PAY_BYTES), .CRC_BYTES(CRC_BYTES)) uRxCtrl (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .strobe(rxStrobe)
  );

  rfc_rx_data #(.PAY_BYTES(PAY_BYTES)) uRxData (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .localAddr(localAddr),
    .strobe(rxStrobe), .outPush(outPush), .outSrc(outSrc),
    .outPayload(outPayload)
  );
endmodule

// File: tb/radio_frame_codec_test.sv
`timescale 1ns/1ps
module radio_frame_codec_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  localAddr = 8'h2A;
  logic        txStart = 1'b0;
  logic [7:0]  txDest = 8'h00;
  logic [31:0] txPayload = 32'h0;
  logic        txReady, txValid, outPush;
  logic [7:0]  txByte, outSrc;
  logic        txAccept = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic        rxValid = 1'b0;
  logic [31:0] outPayload;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  radio_frame_codec uut (
    .clk(clk), .rstN(rstN), .localAddr(localAddr), .txStart(txStart),
    .txDest(txDest), .txPayload(txPayload), .txReady(txReady),
    .txByte(txByte), .txValid(txValid), .txAccept(txAccept),
    .rxByte(rxByte), .rxValid(rxValid), .outPush(outPush),
    .outSrc(outSrc), .outPayload(outPayload)
  );

  // {len, dest, src, payload, expectPush}
  localparam int NV = 10;
  localparam logic [56:0] VEC [NV] = '{
    {8'd8,  8'h2A, 8'h11, 32'hDEADBEEF, 1'b1},
    {8'd8,  8'hFF, 8'h12, 32'h01020304, 1'b1},
    {8'd8,  8'h33, 8'h13, 32'h55555555, 1'b0},
    {8'd8,  8'h00, 8'h14, 32'h66666666, 1'b0},
    {8'd8,  8'h2A, 8'h2A, 32'h77777777, 1'b0},
    {8'd8,  8'hFF, 8'h2A, 32'h88888888, 1'b0},
    {8'd5,  8'h2A, 8'h15, 32'h99999999, 1'b0},
    {8'd12, 8'h2A, 8'h16, 32'hAAAAAAAA, 1'b0},
    {8'd8,  8'h2A, 8'h17, 32'hCAFEF00D, 1'b1},
    {8'd8,  8'hFF, 8'h80, 32'h00000001, 1'b1}
  };
  string tags [NV] = '{"R4", "R5", "R6", "R7", "R8", "R8", "R9", "R9", "R9", "R5"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bodyByte(input int i, input logic [7:0] d, input logic [7:0] s, input logic [31:0] p);
    if (i == 0) return d;
    if (i == 1) return s;
    if (i >= 2 && i <= 5) return p[8*(5-i) +: 8];
    return 8'hC3;
  endfunction

  // Ends at the negedge right after the last byte was taken.
  task automatic sendFrame(input logic [7:0] len, input logic [7:0] d, input logic [7:0] s,
                           input logic [31:0] p, input bit gaps, output bit early);
    early = 0;
    @(negedge clk); rxByte = len; rxValid = 1'b1;
    for (int i = 0; i < int'(len); i++) begin
      @(negedge clk);
      if (outPush) early = 1;
      if (gaps) begin
        rxValid = 1'b0; rxByte = 8'h00;
        @(negedge clk);
        if (outPush) early = 1;
      end
      rxByte = bodyByte(i, d, s, p); rxValid = 1'b1;
    end
    @(negedge clk); rxValid = 1'b0; rxByte = 8'h00;
  endtask

  function automatic logic [7:0] txExp(input int i, input logic [7:0] d, input logic [31:0] p);
    if (i == 0) return 8'h08;
    if (i == 1) return d;
    if (i == 2) return localAddr;
    if (i >= 3 && i <= 6) return p[8*(6-i) +: 8];
    return 8'h00;
  endfunction

  task automatic txRun(input logic [7:0] d, input logic [31:0] p, input bit stall);
    int idx = 0;
    int guard = 0;
    bit prevStall = 0;
    logic [7:0] held = 8'h00;
    @(negedge clk);
    check(txReady == 1'b1, "R1 ready before start", {31'd0, txReady}, 32'd1);
    txDest = d; txPayload = p; txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    check(txReady == 1'b0, "R1 busy after start", {31'd0, txReady}, 32'd0);
    while (idx < 9 && guard < 100) begin
      if (!txValid) check(1'b0, "R2 valid missing", {31'd0, txValid}, 32'd1);
      if (prevStall) check(txByte == held, "R3 hold on stall", {24'd0, txByte}, {24'd0, held});
      if (stall && guard == 1) begin txStart = 1'b1; txDest = 8'h99; txPayload = 32'h0BADF00D; end
      else txStart = 1'b0;
      if (!stall || (guard % 3) != 1) begin
        txAccept = 1'b1;
        check(txByte == txExp(idx, d, p), "R2 byte order", {24'd0, txByte}, {24'd0, txExp(idx, d, p)});
        idx++;
        prevStall = 0;
      end else begin
        txAccept = 1'b0;
        held = txByte;
        prevStall = 1;
      end
      @(negedge clk);
      guard++;
    end
    txAccept = 1'b0; txStart = 1'b0;
    check(txReady && !txValid, "R1 ready after last byte", {30'd0, txReady, txValid}, 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit early;
    logic [31:0] lastGood = 32'h0;
    repeat (3) @(negedge clk);
    // R11 and R1: reset state
    check(outPush == 1'b0, "R11 push at reset", {31'd0, outPush}, 32'd0);
    check(outPayload == 32'h0 && outSrc == 8'h0, "R11 outputs at reset", outPayload, 32'd0);
    check(txReady == 1'b1 && txValid == 1'b0, "R1 tx reset", {30'd0, txReady, txValid}, 32'd2);
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < NV; r++) begin
      logic [7:0] len, d, s; logic [31:0] p; bit ex;
      {len, d, s, p, ex} = VEC[r];
      sendFrame(len, d, s, p, (r % 2) == 1, early);
      check(!early, "R10 no early push", {31'd0, early}, 32'd0);
      check(outPush == ex, tags[r], {31'd0, outPush}, {31'd0, ex});
      if (ex) begin
        check(outPayload == p, "R4 payload", outPayload, p);
        check(outSrc == s, "R4 source", {24'd0, outSrc}, {24'd0, s});
        lastGood = p;
      end else begin
        check(outPayload == lastGood, "R10 payload kept", outPayload, lastGood);
      end
      @(negedge clk);
      check(outPush == 1'b0, "R4 single push", {31'd0, outPush}, 32'd0);
    end

    // R9: zero-length frame, then a good frame
    sendFrame(8'd0, 8'h00, 8'h00, 32'h0, 1'b0, early);
    check(outPush == 1'b0, "R9 zero length", {31'd0, outPush}, 32'd0);
    sendFrame(8'd8, 8'h2A, 8'h21, 32'h12345678, 1'b0, early);
    check(outPush == 1'b1 && outPayload == 32'h12345678, "R9 resync after zero length", outPayload, 32'h12345678);

    // R4: address change without reset
    localAddr = 8'h40;
    @(negedge clk);
    sendFrame(8'd8, 8'h2A, 8'h22, 32'h11111111, 1'b0, early);
    check(outPush == 1'b0, "R6 old address dropped", {31'd0, outPush}, 32'd0);
    sendFrame(8'd8, 8'h40, 8'h2A, 32'h22222222, 1'b0, early);
    check(outPush == 1'b1 && outSrc == 8'h2A, "R4 new address accepted", {24'd0, outSrc}, 32'h2A);

    // Transmit
    txRun(8'h5C, 32'hA1B2C3D4, 1'b0);
    txRun(8'hFF, 32'h0F1E2D3C, 1'b1);
    check(txByte == 8'h08 || !txValid, "R1 start while busy ignored", {31'd0, txValid}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule